// File: doc/BRIEF.md
# Block Chaining and Word Swap Wrapper

This block sits between a 32-bit word stream and a 128-bit block cipher core. It gathers four input words into one block and applies one of three chaining modes: independent blocks (ECB), cipher block chaining (CBC) or counter mode (CTR). It hands the core one 128-bit operand together with a direction select. When the core returns its result, the block combines that result with the chaining value and sends the outcome back out as four words. A 128-bit chaining register carries state from one block to the next. The register is seeded from four initialisation words, where word 0 is a 32-bit counter and words 1 to 3 form a 96-bit nonce.

Every word passes through a selectable swap on the way in, before it is assembled into the block. Every result word passes through the same kind of swap on the way out. The cipher core in this project is a stand-in with a fixed key, so the chaining logic can be tested on its own. Key scheduling and register decoding belong to the surrounding system.

Top module: `blk_chain_wrap`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, the chaining register and the IV words are zero, and no IV load is pending.
- R2: Four accepted input words form one block, with the first word in bits [31:0] and the fourth in bits [127:96]. After the fourth word, in_ready stays 0 until the result has been sent out. The result appears as four out_valid words on consecutive cycles, bits [31:0] first.
- R3: With chain code 0 (ECB), or with the unused code 3, the core gets the block itself and the output is the core result. The chaining register has no effect on the output.
- R4: With chain code 1 (CBC) and cfg_decrypt=0, the core gets the block XOR the chaining value. The output is the core result, and that result becomes the next chaining value.
- R5: With chain code 1 and cfg_decrypt=1, the core gets the block in the decrypt direction. The output is the core result XOR the chaining value, and the block just consumed becomes the next chaining value.
- R6: With chain code 2 (CTR), the core encrypts the chaining value whatever cfg_decrypt is set to. The output is the core result XOR the block. After the block, bits [31:0] of the chaining value increase by one modulo 2^32 and bits [127:32] stay the same.
- R7: cfg_swap applies to every input word and every output word. Code 0 leaves the word unchanged, 1 exchanges its two halfwords, 2 reverses its byte order and 3 reverses its bit order.
- R8: A pulse on iv_wr writes iv_data into IV word iv_sel, where word 0 is bits [31:0]. The IV words replace the chaining value at the start of the next block, even in the middle of a chain.
- R9: The stand-in core computes encrypt E(x) = rotate-left-by-1(x XOR KEY) and decrypt D(y) = rotate-right-by-1(y) XOR KEY on 128 bits. Its result arrives CORE_LAT cycles after the operand is taken.
- R10: Words offered while in_ready is 0 are ignored and do not change the block in progress or any later block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chain | input | 2 | Chaining mode: 0 ECB, 1 CBC, 2 CTR, 3 treated as ECB |
| cfg_decrypt | input | 1 | 1 selects the decrypt direction |
| cfg_swap | input | 2 | Word swap: 0 none, 1 halfword, 2 byte, 3 bit |
| iv_wr | input | 1 | IV word write strobe |
| iv_sel | input | 2 | IV word index |
| iv_data | input | 32 | IV word value |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Input word |
| in_ready | output | 1 | The block is collecting input words |
| out_valid | output | 1 | Output word present |
| out_word | output | 32 | Output word |

## Verification
On every cycle, the assertions check that the core's operand and direction match the latched chaining mode, and that CTR keeps the nonce unchanged. They also check that a pending IV load is the value taken at block start, that the collected block is not touched while it is being processed, and that each output burst is four words long. Only the bench scenarios can show the full arithmetic: CBC chaining across several blocks, counter wrap from all ones to zero, an IV reload in the middle of a chain, and the effect of all four swaps in both directions. These are shown by comparing complete output blocks against a model computed in the bench.

// File: rtl/blk_chain_pkg.sv
// Shared encodings for the block chaining wrapper.
// Assumes the mode and swap inputs are two bits wide.
package blk_chain_pkg;

    typedef enum logic [1:0] {
        CH_ECB = 2'd0,
        CH_CBC = 2'd1,
        CH_CTR = 2'd2,
        CH_RSV = 2'd3
    } chain_e;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_HALF = 2'd1,
        SW_BYTE = 2'd2,
        SW_BIT  = 2'd3
    } swap_e;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_RUN     = 2'd2,
        ST_EMIT    = 2'd3
    } wrap_state_e;

endpackage

// File: rtl/blk_word_swap.sv
// Rearranges one data word in one of four ways: unchanged, halfwords
// exchanged, bytes reversed or bits reversed.
// Assumes W is a multiple of 16. Purely combinational.
module blk_word_swap
    import blk_chain_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;
    localparam int HALF   = W / 2;

    logic [W-1:0] half_sw;
    logic [W-1:0] byte_sw;
    logic [W-1:0] bit_sw;

    assign half_sw = {din[HALF-1:0], din[W-1:HALF]};

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_sw[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_sw[i] = din[W-1-i];
    end

    // Pick the arrangement named by sel.
    always_comb begin
        unique case (swap_e'(sel))
            SW_HALF: dout = half_sw;
            SW_BYTE: dout = byte_sw;
            SW_BIT:  dout = bit_sw;
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/blk_cipher_stub.sv
// Stand-in for the block cipher core. Encrypt is rotl1(x ^ KEY) and
// decrypt is rotr1(y) ^ KEY, which undo each other. The result comes
// out LAT cycles after start.
// Assumes start is only raised while the stub is idle, and LAT >= 1.
module blk_cipher_stub #(
    parameter int           BLK = 128,
    parameter logic [BLK-1:0] KEY = '0,
    parameter int           LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           dec,
    input  logic [BLK-1:0] op,
    output logic           done,
    output logic [BLK-1:0] res
);
    localparam int CW = $clog2(LAT + 1);

    logic           busy;
    logic [CW-1:0]  cnt;
    logic [BLK-1:0] op_q;
    logic           dec_q;
    logic [BLK-1:0] enc_val;
    logic [BLK-1:0] dec_val;
    logic [BLK-1:0] mixed;

    assign mixed   = op_q ^ KEY;
    assign enc_val = {mixed[BLK-2:0], mixed[BLK-1]};
    assign dec_val = {op_q[0], op_q[BLK-1:1]} ^ KEY;

    // Take the operand, count out the latency and produce one result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            op_q  <= '0;
            dec_q <= 1'b0;
            done  <= 1'b0;
            res   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                cnt   <= '0;
                op_q  <= op;
                dec_q <= dec;
            end else if (busy) begin
                if (cnt == CW'(LAT - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    res  <= dec_q ? dec_val : enc_val;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9: an operand is only offered to an idle core
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R9: the result is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/blk_chain_mix.sv
// Combinational chaining arithmetic. For each mode it forms the core
// operand and direction, the block result and the next chaining value.
// Assumes core_res is valid whenever result and chain_nxt are used.
module blk_chain_mix
    import blk_chain_pkg::*;
#(
    parameter int BLK  = 128,
    parameter int CTRW = 32
) (
    input  logic [1:0]     mode,
    input  logic           decrypt,
    input  logic [BLK-1:0] blk,
    input  logic [BLK-1:0] chain,
    input  logic [BLK-1:0] core_res,
    output logic [BLK-1:0] core_op,
    output logic           core_dec,
    output logic [BLK-1:0] result,
    output logic [BLK-1:0] chain_nxt
);
    logic [CTRW-1:0] ctr_inc;

    assign ctr_inc = chain[CTRW-1:0] + 1'b1;

    // Select operand, direction, result and next chaining value by mode.
    always_comb begin
        core_op   = blk;
        core_dec  = decrypt;
        result    = core_res;
        chain_nxt = chain;
        unique case (chain_e'(mode))
            CH_CBC: begin
                if (decrypt) begin
                    result    = core_res ^ chain;
                    chain_nxt = blk;
                end else begin
                    core_op   = blk ^ chain;
                    chain_nxt = core_res;
                end
            end
            CH_CTR: begin
                core_op   = chain;
                core_dec  = 1'b0;
                result    = core_res ^ blk;
                chain_nxt = {chain[BLK-1:CTRW], ctr_inc};
            end
            default: begin
                core_op = blk;
            end
        endcase
    end

endmodule

// File: rtl/blk_chain_wrap.sv
// Top of the chaining wrapper. It collects NWORDS swapped input words
// into a block, runs the block through the core with the chaining
// arithmetic, and sends the result back out as swapped words, lowest
// first. IV writes are held and take effect at the next block start.
// Assumes configuration is stable while a block is being collected;
// the mode and output swap are latched when the core is started.
module blk_chain_wrap
    import blk_chain_pkg::*;
#(
    parameter int           WORD     = 32,
    parameter int           NWORDS   = 4,
    parameter int           CTR_W    = 32,
    parameter int           CORE_LAT = 3,
    parameter logic [WORD*NWORDS-1:0] KEY =
        128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_chain,
    input  logic                      cfg_decrypt,
    input  logic [1:0]                cfg_swap,
    input  logic                      iv_wr,
    input  logic [$clog2(NWORDS)-1:0] iv_sel,
    input  logic [WORD-1:0]           iv_data,
    input  logic                      in_valid,
    input  logic [WORD-1:0]           in_word,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [WORD-1:0]           out_word
);
    localparam int BLK  = WORD * NWORDS;
    localparam int IDXW = $clog2(NWORDS);
    localparam logic [IDXW-1:0] LAST = IDXW'(NWORDS - 1);

    wrap_state_e    state;
    logic [IDXW-1:0] idx;
    logic [BLK-1:0] blk_q;
    logic [BLK-1:0] iv_q;
    logic           iv_pend;
    logic [BLK-1:0] chain_q;
    logic [BLK-1:0] chain_use;
    logic [1:0]     mode_q;
    logic           dec_q;
    logic [1:0]     swap_q;
    logic [BLK-1:0] res_q;

    logic [WORD-1:0] in_sw;
    logic [WORD-1:0] res_word;
    logic [WORD-1:0] out_sw;
    logic [BLK-1:0]  chain_eff;
    logic [BLK-1:0]  mix_chain;
    logic [1:0]      mix_mode;
    logic            mix_dec;
    logic [BLK-1:0]  core_op;
    logic            core_dec;
    logic [BLK-1:0]  mix_result;
    logic [BLK-1:0]  mix_chain_nxt;
    logic            core_start;
    logic            core_done;
    logic [BLK-1:0]  core_res;

    blk_word_swap #(.W(WORD)) u_in_swap (
        .sel  (cfg_swap),
        .din  (in_word),
        .dout (in_sw)
    );

    assign res_word = res_q[idx*WORD +: WORD];

    blk_word_swap #(.W(WORD)) u_out_swap (
        .sel  (swap_q),
        .din  (res_word),
        .dout (out_sw)
    );

    assign chain_eff  = iv_pend ? iv_q : chain_q;
    assign core_start = (state == ST_LAUNCH);
    assign mix_chain  = core_start ? chain_eff : chain_use;
    assign mix_mode   = core_start ? cfg_chain : mode_q;
    assign mix_dec    = core_start ? cfg_decrypt : dec_q;

    blk_chain_mix #(.BLK(BLK), .CTRW(CTR_W)) u_mix (
        .mode      (mix_mode),
        .decrypt   (mix_dec),
        .blk       (blk_q),
        .chain     (mix_chain),
        .core_res  (core_res),
        .core_op   (core_op),
        .core_dec  (core_dec),
        .result    (mix_result),
        .chain_nxt (mix_chain_nxt)
    );

    blk_cipher_stub #(.BLK(BLK), .KEY(KEY), .LAT(CORE_LAT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (core_start),
        .dec   (core_dec),
        .op    (core_op),
        .done  (core_done),
        .res   (core_res)
    );

    assign in_ready  = (state == ST_COLLECT);
    assign out_valid = (state == ST_EMIT);
    assign out_word  = out_sw;

    // Hold IV words written by the host and mark them for the next block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q    <= '0;
            iv_pend <= 1'b0;
        end else begin
            if (iv_wr) begin
                iv_q[iv_sel*WORD +: WORD] <= iv_data;
                iv_pend <= 1'b1;
            end else if (core_start) begin
                iv_pend <= 1'b0;
            end
        end
    end

    // Sequence collect, launch, run and emit, and keep the chaining state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_COLLECT;
            idx       <= '0;
            blk_q     <= '0;
            chain_q   <= '0;
            chain_use <= '0;
            mode_q    <= '0;
            dec_q     <= 1'b0;
            swap_q    <= '0;
            res_q     <= '0;
        end else begin
            unique case (state)
                ST_COLLECT: begin
                    if (in_valid) begin
                        blk_q[idx*WORD +: WORD] <= in_sw;
                        if (idx == LAST) begin
                            idx   <= '0;
                            state <= ST_LAUNCH;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_LAUNCH: begin
                    chain_use <= chain_eff;
                    mode_q    <= cfg_chain;
                    dec_q     <= cfg_decrypt;
                    swap_q    <= cfg_swap;
                    state     <= ST_RUN;
                end
                ST_RUN: begin
                    if (core_done) begin
                        res_q   <= mix_result;
                        chain_q <= mix_chain_nxt;
                        idx     <= '0;
                        state   <= ST_EMIT;
                    end
                end
                default: begin
                    if (idx == LAST) begin
                        idx   <= '0;
                        state <= ST_COLLECT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: an output burst continues until its last word
    p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx != LAST) |=> out_valid);

    // R3: in ECB the core sees the block itself
    p_ecb_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && chain_e'(cfg_chain) == CH_ECB) |-> core_op == blk_q);

    // R5: CBC decrypt sends the raw block the decrypt way
    p_cbc_dec_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && chain_e'(cfg_chain) == CH_CBC && cfg_decrypt)
        |-> (core_op == blk_q && core_dec));

    // R6: CTR always runs the core in the encrypt direction
    p_ctr_encrypt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && chain_e'(cfg_chain) == CH_CTR) |-> !core_dec);

    // R6: the nonce part of the chaining value survives a CTR block
    p_ctr_nonce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && core_done && chain_e'(mode_q) == CH_CTR)
        |=> chain_q[BLK-1:CTR_W] == $past(chain_use[BLK-1:CTR_W]));

    // R8: a pending IV load becomes the chaining value at block start
    p_iv_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && iv_pend) |=> chain_use == $past(iv_q));

    // R10: the block under processing is not disturbed by input words
    p_blk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COLLECT) |=> $stable(blk_q));

endmodule

// File: tb/sim_blk_chain_wrap.sv
// Sweeps every chaining mode, direction and swap code across multi-block
// chains with an IV reload, and compares whole blocks against a model.
module sim_blk_chain_wrap;
    localparam logic [127:0] KEY = 128'hA5C3_0F96_1234_5678_9ABC_DEF0_5A5A_C3C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_chain = 2'd0;
    logic        cfg_decrypt = 1'b0;
    logic [1:0]  cfg_swap = 2'd0;
    logic        iv_wr = 1'b0;
    logic [1:0]  iv_sel = 2'd0;
    logic [31:0] iv_data = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int fails = 0;
    logic [127:0] c_m;

    always #5 clk = ~clk;

    blk_chain_wrap #(.KEY(KEY)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_chain(cfg_chain), .cfg_decrypt(cfg_decrypt),
        .cfg_swap(cfg_swap), .iv_wr(iv_wr), .iv_sel(iv_sel), .iv_data(iv_data),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [31:0] swapw(input logic [31:0] w, input logic [1:0] s);
        logic [31:0] r;
        case (s)
            2'd1: r = {w[15:0], w[31:16]};
            2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd3: for (int i = 0; i < 32; i++) r[i] = w[31-i];
            default: r = w;
        endcase
        return r;
    endfunction

    function automatic logic [127:0] f_enc(input logic [127:0] x);
        logic [127:0] m;
        m = x ^ KEY;
        return {m[126:0], m[127]};
    endfunction

    function automatic logic [127:0] f_dec(input logic [127:0] y);
        return {y[0], y[127:1]} ^ KEY;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_iv(input logic [127:0] iv);
        for (int i = 0; i < 4; i++) begin
            iv_wr = 1'b1; iv_sel = 2'(i); iv_data = iv[i*32 +: 32];
            @(negedge clk);
        end
        iv_wr = 1'b0;
    endtask

    // Send one raw block, offer junk while busy, and compare the result.
    task automatic run_block(input logic [127:0] raw, input string req);
        logic [127:0] x, y, c_n, exp, got;
        for (int i = 0; i < 4; i++) x[i*32 +: 32] = swapw(raw[i*32 +: 32], cfg_swap);
        case (cfg_chain)
            2'd1: begin
                if (cfg_decrypt) begin y = f_dec(x) ^ c_m; c_n = x; end
                else begin y = f_enc(x ^ c_m); c_n = y; end
            end
            2'd2: begin
                y = f_enc(c_m) ^ x;
                c_n = {c_m[127:32], c_m[31:0] + 32'd1};
            end
            default: begin y = cfg_decrypt ? f_dec(x) : f_enc(x); c_n = c_m; end
        endcase
        for (int i = 0; i < 4; i++) exp[i*32 +: 32] = swapw(y[i*32 +: 32], cfg_swap);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_word = raw[i*32 +: 32];
            @(negedge clk);
        end
        // R10: junk offered while the block is being processed
        in_word = 32'hDEAD_BEEF;
        check(!in_ready, "R2 ready low", {127'd0, in_ready}, 128'd0);
        while (!out_valid) @(negedge clk);
        got = '0;
        for (int i = 0; i < 4; i++) begin
            check(out_valid, "R2 burst", {127'd0, out_valid}, 128'd1);
            got[i*32 +: 32] = out_word;
            if (i == 3) in_valid = 1'b0;
            @(negedge clk);
        end
        check(got == exp, req, got, exp);
        c_m = c_n;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [127:0] raw, iv;
        string tag;
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(in_ready && !out_valid, "R1 reset", {126'd0, in_ready, out_valid}, 128'd2);
        for (int m = 0; m < 3; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 0; s < 4; s++) begin
                    cfg_chain = 2'(m); cfg_decrypt = d[0]; cfg_swap = 2'(s);
                    // counter of all ones exercises the R6 wrap on the second block
                    iv = {32'h1111_0000 + 32'(m*8+s), 32'h2222_3333 ^ 32'(d),
                          32'h4444_5555, 32'hFFFF_FFFF};
                    load_iv(iv);
                    c_m = iv;
                    if (m == 0) tag = "R3 R9 ECB";
                    else if (m == 2) tag = "R6 CTR";
                    else if (d == 1) tag = "R5 CBC dec";
                    else tag = "R4 CBC enc";
                    if (s != 0) tag = {tag, " R7 swap"};
                    for (int b = 0; b < 2; b++) begin
                        k++;
                        raw = {32'h0123_4567 * 32'(k), 32'h89AB_CDEF ^ 32'(k*977),
                               32'hC0DE_0000 + 32'(k), 32'h9E37_79B9 * 32'(k+3)};
                        run_block(raw, tag);
                    end
                    // R8: reload the IV in the middle of the chain
                    iv = {32'hABCD_0000 + 32'(k), 32'h5555_AAAA, 32'h0F0F_0F0F, 32'h7FFF_FFF0};
                    load_iv(iv);
                    c_m = iv;
                    k++;
                    raw = {32'h1357_9BDF + 32'(k), 32'h2468_ACE0, 32'(k), 32'hFEDC_BA98};
                    run_block(raw, {tag, " R8 reload"});
                end
            end
        end
        // R3: ECB ignores the IV words
        cfg_chain = 2'd3; cfg_decrypt = 1'b0; cfg_swap = 2'd0;
        load_iv(128'hFFFF_0000_FFFF_0000_1234_4321_8888_7777);
        run_block(128'h0000_1111_2222_3333_4444_5555_6666_7777, "R3 code3");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule